// File: doc/BRIEF.md
# Pixel-Parallel SIMD Element Array

A rectangular mesh of identical processing elements that all run the same instruction, broadcast by an external sequencer, on each clock. Each element holds six general registers, a neighbour-exchange register and a scaling register, all signed fixed-point words. It also holds a one-bit activity flag. Each element also sees its own pixel word. There is no separate adder or subtractor. Each write stores the saturated negative of the sum of every source that the instruction selects. A program adds by selecting several sources, and subtracts by selecting a value that has already been negated.

An element whose flag is clear ignores register writes. The flag itself is loaded by a sign test on the selected sum, or set in every element at once, so a program builds conditional steps such as thresholding out of ordinary transfers. A readout port adds up one chosen register over every element whose row and column are both selected. One element, a row, a column or the whole array can be read this way.

Top module: `pixel_simd_array`

## Requirements
- R1: After reset every register of every element reads zero and every activity flag is set, so the first transfer writes all elements.
- R2: A transfer (opcode 1) writes, in every active element, the negated sum of all selected sources into the register named by the destination code. Codes 0 to 5 are general registers, 6 is the exchange register and 7 is the scaling register. Source-select bits 0 to 5 pick general registers, bit 6 the exchange register, bit 7 the scaled value, bit 8 the pixel and bit 9 the immediate. The result is readable in the cycle after the clock edge.
- R3: Results saturate at the largest positive and most negative word instead of wrapping. Negating the most negative word gives the largest positive word.
- R4: The 7-bit immediate is two's complement and is sign-extended to the word width.
- R5: Source bit 8 samples the pixel word of that element. Element (row r, column c) has index r*COLS+c, and its pixel sits at bits [index*W +: W] of the pixel bus.
- R6: The scaled source is the sum, over each set bit i of the 3-bit scale code, of the scaling register shifted arithmetically right by i+1.
- R7: An exchange (opcode 2) loads the exchange register of each active element with the saturated negated sum of the selected sources of one neighbour. Direction 0 is the row above, 1 the column to the right, 2 the row below and 3 the column to the left. A neighbour outside the array supplies zero.
- R8: A compare (opcode 3) sets the flag of every element whose selected sum is zero or positive and clears it where the sum is negative, whatever the previous flag.
- R9: Opcode 4 sets the activity flag in every element.
- R10: An element with a clear flag keeps all its registers unchanged on transfers and exchanges.
- R11: The readout is the sum of the register named by the 3-bit readout select over all elements whose row bit and column bit are both set. It is zero when no element is selected, and it follows the select inputs without a clock.
- R12: Opcode 0 and the unused codes 5 to 7 change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Broadcast opcode |
| src_i | input | 10 | Source-select bits |
| dst_i | input | 3 | Destination register code |
| dir_i | input | 2 | Neighbour direction for exchange |
| imm_i | input | 7 | Signed immediate |
| scl_i | input | 3 | Scale code |
| pix_i | input | ROWS*COLS*W | Per-element pixel words |
| rd_row_i | input | ROWS | Readout row selects |
| rd_col_i | input | COLS | Readout column selects |
| rd_sel_i | input | 3 | Register code for readout |
| rd_sum_o | output | OW | Summed readout |

## Verification
A transfer, exchange or flag change takes effect at the rising edge that samples the instruction. Because the readout is combinational, a register result can be seen as soon as the readout selects are set after that edge. The bench drives each instruction at a falling edge and lets exactly one rising edge take it. It then sets the readout selects at the next falling edge, with a no-op on the instruction lines, and samples one nanosecond later. A flag result has no port of its own, so the bench observes it one instruction later, by issuing a probe transfer of a known immediate and reading back which elements accepted it.

// File: rtl/simd_pkg.sv
// Shared encodings for the pixel-parallel SIMD array.
// Assumes: opcode, source-bit and register-code positions are fixed here and
// decoded identically by every element and by the bench.
package simd_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_XFER = 3'd1,
        OP_NEWS = 3'd2,
        OP_CMP  = 3'd3,
        OP_SETF = 3'd4
    } simd_op_e;

    localparam int NSRC      = 10;
    localparam int NGEN      = 6;
    localparam int NREG      = 8;
    localparam int SRC_NEWS  = 6;
    localparam int SRC_SCALE = 7;
    localparam int SRC_PIX   = 8;
    localparam int SRC_IMM   = 9;
    localparam int REG_NEWS  = 6;
    localparam int REG_SCALE = 7;
    localparam int DIR_N     = 0;
    localparam int DIR_E     = 1;
    localparam int DIR_S     = 2;
    localparam int DIR_W     = 3;
endpackage

// File: rtl/simd_pe.sv
// One processing element: register file, source summing bus, scaling path,
// neighbour exchange and activity flag.
// Assumes: SW is wide enough that the sum of all sources never wraps; the
// neighbour sums arrive already zeroed at the array edge.
module simd_pe
    import simd_pkg::*;
#(
    parameter int W  = 12,
    parameter int SW = 17,
    parameter int SK = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               op_i,
    input  logic [NSRC-1:0]          src_i,
    input  logic [2:0]               dst_i,
    input  logic [1:0]               dir_i,
    input  logic signed [W-1:0]      imm_i,
    input  logic [SK-1:0]            scl_i,
    input  logic signed [W-1:0]      pix_i,
    input  logic [3:0][SW-1:0]       nbr_i,
    input  logic [2:0]               rd_sel_i,
    output logic signed [SW-1:0]     bus_o,
    output logic signed [W-1:0]      rd_val_o,
    output logic                     flag_o
);
    localparam logic signed [SW-1:0] HI = SW'((2 ** (W - 1)) - 1);
    localparam logic signed [SW-1:0] LO = -HI - SW'(1);

    logic signed [W-1:0]  rf [NREG];
    logic signed [SW-1:0] scaled;
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] nbr_sel;
    logic                 flag_q;

    function automatic logic signed [SW-1:0] ext(input logic signed [W-1:0] x);
        return {{(SW - W){x[W-1]}}, x};
    endfunction

    function automatic logic signed [W-1:0] neg_sat(input logic signed [SW-1:0] v);
        logic signed [SW-1:0] n;
        n = -v;
        if (n > HI) return HI[W-1:0];
        if (n < LO) return LO[W-1:0];
        return n[W-1:0];
    endfunction

    // Binary-weighted scaling: add halved copies of the scaling register.
    always_comb begin
        scaled = '0;
        for (int i = 0; i < SK; i++) begin
            if (scl_i[i]) scaled = scaled + (ext(rf[REG_SCALE]) >>> (i + 1));
        end
    end

    // Source summing bus: total of every selected source.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NGEN; i++) begin
            if (src_i[i]) acc = acc + ext(rf[i]);
        end
        if (src_i[SRC_NEWS])  acc = acc + ext(rf[REG_NEWS]);
        if (src_i[SRC_SCALE]) acc = acc + scaled;
        if (src_i[SRC_PIX])   acc = acc + ext(pix_i);
        if (src_i[SRC_IMM])   acc = acc + ext(imm_i);
    end

    assign nbr_sel  = nbr_i[dir_i];
    assign bus_o    = acc;
    assign rd_val_o = rf[rd_sel_i];
    assign flag_o   = flag_q;

    // Register file and flag update for one broadcast instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
            flag_q <= 1'b1;
        end else begin
            case (op_i)
                OP_XFER: if (flag_q) rf[dst_i] <= neg_sat(acc);
                OP_NEWS: if (flag_q) rf[REG_NEWS] <= neg_sat(nbr_sel);
                OP_CMP:  flag_q <= ~acc[SW-1];
                OP_SETF: flag_q <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/simd_readout.sv
// Summing readout: adds one word per element over the selected rows x columns.
// Assumes: OW holds ROWS*COLS worst-case words without overflow.
module simd_readout #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 12,
    parameter int OW   = 17
) (
    input  logic [ROWS*COLS*W-1:0] vals_i,
    input  logic [ROWS-1:0]        row_i,
    input  logic [COLS-1:0]        col_i,
    output logic signed [OW-1:0]   sum_o
);
    // Accumulate sign-extended words of elements on a selected row and column.
    always_comb begin
        sum_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (row_i[r] && col_i[c]) begin
                    sum_o = sum_o + {{(OW - W){vals_i[(r * COLS + c) * W + W - 1]}},
                                     vals_i[(r * COLS + c) * W +: W]};
                end
            end
        end
    end
endmodule

// File: rtl/pixel_simd_array.sv
// Top of the SIMD element mesh: instantiates ROWS x COLS elements, wires the
// four-neighbour exchange with zero at the edges, and the summing readout.
// Assumes: the sequencer holds one instruction per clock on the op/src/dst lines.
module pixel_simd_array
    import simd_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 12,
    parameter int IW   = 7,
    parameter int SK   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             op_i,
    input  logic [9:0]             src_i,
    input  logic [2:0]             dst_i,
    input  logic [1:0]             dir_i,
    input  logic [IW-1:0]          imm_i,
    input  logic [SK-1:0]          scl_i,
    input  logic [ROWS*COLS*W-1:0] pix_i,
    input  logic [ROWS-1:0]        rd_row_i,
    input  logic [COLS-1:0]        rd_col_i,
    input  logic [2:0]             rd_sel_i,
    output logic [W+$clog2(ROWS*COLS):0] rd_sum_o
);
    localparam int N  = ROWS * COLS;
    localparam int SW = W + $clog2(NSRC) + 1;
    localparam int OW = W + $clog2(N) + 1;

    logic [N-1:0][SW-1:0]  bus_all;
    logic [N*W-1:0]        rd_vals;
    logic [N-1:0]          flag_vec;
    logic signed [W-1:0]   imm_ext;
    logic signed [OW-1:0]  rd_sum;

    assign imm_ext  = {{(W - IW){imm_i[IW-1]}}, imm_i};
    assign rd_sum_o = rd_sum;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic [3:0][SW-1:0] nbr;
            logic signed [W-1:0] rv;

            if (r > 0) begin : g_n
                assign nbr[DIR_N] = bus_all[IDX-COLS];
            end else begin : g_n_edge
                assign nbr[DIR_N] = '0;
            end
            if (c < COLS - 1) begin : g_e
                assign nbr[DIR_E] = bus_all[IDX+1];
            end else begin : g_e_edge
                assign nbr[DIR_E] = '0;
            end
            if (r < ROWS - 1) begin : g_s
                assign nbr[DIR_S] = bus_all[IDX+COLS];
            end else begin : g_s_edge
                assign nbr[DIR_S] = '0;
            end
            if (c > 0) begin : g_w
                assign nbr[DIR_W] = bus_all[IDX-1];
            end else begin : g_w_edge
                assign nbr[DIR_W] = '0;
            end

            simd_pe #(.W(W), .SW(SW), .SK(SK)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .op_i     (op_i),
                .src_i    (src_i),
                .dst_i    (dst_i),
                .dir_i    (dir_i),
                .imm_i    (imm_ext),
                .scl_i    (scl_i),
                .pix_i    (pix_i[IDX*W +: W]),
                .nbr_i    (nbr),
                .rd_sel_i (rd_sel_i),
                .bus_o    (bus_all[IDX]),
                .rd_val_o (rv),
                .flag_o   (flag_vec[IDX])
            );
            assign rd_vals[IDX*W +: W] = rv;
        end
    end

    simd_readout #(.ROWS(ROWS), .COLS(COLS), .W(W), .OW(OW)) u_rd (
        .vals_i (rd_vals),
        .row_i  (rd_row_i),
        .col_i  (rd_col_i),
        .sum_o  (rd_sum)
    );
endmodule

// File: rtl/simd_array_chk.sv
// Property checker for the SIMD element mesh, bound to the top module.
// Assumes: flag vector is brought out of the top as flag_vec.
module simd_array_chk
    import simd_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 12,
    parameter int IW   = 7,
    parameter int OW   = 17
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           op_i,
    input logic [NSRC-1:0]      src_i,
    input logic [IW-1:0]        imm_i,
    input logic [ROWS-1:0]      rd_row_i,
    input logic [COLS-1:0]      rd_col_i,
    input logic [OW-1:0]        rd_sum_o,
    input logic [ROWS*COLS-1:0] flags
);
    localparam int N = ROWS * COLS;
    localparam logic signed [OW-1:0] HI = OW'((2 ** (W - 1)) - 1);
    localparam logic signed [OW-1:0] LO = -HI - OW'(1);

    // R9
    setf_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SETF) |=> (&flags));

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_CMP && op_i != OP_SETF) |=> $stable(flags));

    // R8
    cmp_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP && src_i == NSRC'(1 << SRC_IMM)) |=> (flags == {N{~$past(imm_i[IW-1])}}));

    // R11
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_row_i == '0 || rd_col_i == '0) |-> (rd_sum_o == '0));

    // R3
    single_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_row_i) == 1 && $countones(rd_col_i) == 1)
        |-> ($signed(rd_sum_o) <= HI && $signed(rd_sum_o) >= LO));
endmodule

bind pixel_simd_array simd_array_chk #(
    .ROWS(ROWS), .COLS(COLS), .W(W), .IW(IW), .OW(W + $clog2(ROWS*COLS) + 1)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .src_i    (src_i),
    .imm_i    (imm_i),
    .rd_row_i (rd_row_i),
    .rd_col_i (rd_col_i),
    .rd_sum_o (rd_sum_o),
    .flags    (flag_vec)
);

// File: tb/sim_pixel_simd_array.sv
// Bench for the SIMD element mesh: directed corners plus seeded random
// programs, checked against a behavioural model held in bench arrays.
`timescale 1ns/1ps
module sim_pixel_simd_array;
    import simd_pkg::*;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int N    = ROWS * COLS;
    localparam int W    = 12;
    localparam int OW   = W + $clog2(N) + 1;
    localparam int HI   = (1 << (W - 1)) - 1;
    localparam int LO   = -HI - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       op = 3'd0;
    logic [9:0]       src = '0;
    logic [2:0]       dst = '0;
    logic [1:0]       dir = '0;
    logic [6:0]       imm = '0;
    logic [2:0]       scl = '0;
    logic [N*W-1:0]   pix = '0;
    logic [ROWS-1:0]  rrow = '0;
    logic [COLS-1:0]  rcol = '0;
    logic [2:0]       rsel = '0;
    logic [OW-1:0]    rsum;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int mreg [N][8];
    bit mflag [N];
    int mpix [N];

    always #2 clk = ~clk;

    pixel_simd_array u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src_i(src), .dst_i(dst),
        .dir_i(dir), .imm_i(imm), .scl_i(scl), .pix_i(pix),
        .rd_row_i(rrow), .rd_col_i(rcol), .rd_sel_i(rsel), .rd_sum_o(rsum)
    );

    function automatic int satw(int v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    function automatic int esum(int e, logic [9:0] s, int iv, logic [2:0] k);
        int a = 0;
        for (int i = 0; i < 7; i++) if (s[i]) a += mreg[e][i];
        if (s[7]) for (int i = 0; i < 3; i++) if (k[i]) a += (mreg[e][7] >>> (i + 1));
        if (s[8]) a += mpix[e];
        if (s[9]) a += iv;
        return a;
    endfunction

    function automatic int nbr(int e, int d);
        int r = e / COLS;
        int c = e % COLS;
        case (d)
            0: return (r > 0) ? e - COLS : -1;
            1: return (c < COLS - 1) ? e + 1 : -1;
            2: return (r < ROWS - 1) ? e + COLS : -1;
            default: return (c > 0) ? e - 1 : -1;
        endcase
    endfunction

    task automatic exec(input logic [2:0] o, input logic [9:0] s, input logic [2:0] d,
                        input logic [1:0] dr, input int iv, input logic [2:0] k);
        int nr [N][8];
        bit nf [N];
        @(negedge clk);
        op = o; src = s; dst = d; dir = dr; imm = iv[6:0]; scl = k;
        for (int e = 0; e < N; e++) pix[e*W +: W] = mpix[e][W-1:0];
        @(posedge clk);
        nr = mreg;
        nf = mflag;
        for (int e = 0; e < N; e++) begin
            case (o)
                3'd1: if (mflag[e]) nr[e][d] = satw(-esum(e, s, iv, k));
                3'd2: if (mflag[e]) begin
                    int n = nbr(e, dr);
                    nr[e][6] = (n < 0) ? 0 : satw(-esum(n, s, iv, k));
                end
                3'd3: nf[e] = (esum(e, s, iv, k) >= 0);
                3'd4: nf[e] = 1'b1;
                default: ;
            endcase
        end
        mreg = nr;
        mflag = nf;
    endtask

    task automatic chk_rd(input logic [ROWS-1:0] rows, input logic [COLS-1:0] cols,
                          input logic [2:0] sel, input string tag);
        int exp = 0;
        int got;
        @(negedge clk);
        op = 3'd0; rrow = rows; rcol = cols; rsel = sel;
        #1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (rows[r] && cols[c]) exp += mreg[r*COLS+c][sel];
        got = $signed(rsum);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s sel=%0d rows=%b cols=%b got %0d expected %0d",
                     tag, sel, rows, cols, got, exp);
        end
    endtask

    task automatic chk_elem(input int e, input logic [2:0] sel, input string tag);
        chk_rd(ROWS'(1 << (e / COLS)), COLS'(1 << (e % COLS)), sel, tag);
    endtask

    task automatic chk_every(input logic [2:0] sel, input string tag);
        for (int e = 0; e < N; e++) chk_elem(e, sel, tag);
    endtask

    task automatic rand_pix();
        for (int e = 0; e < N; e++) mpix[e] = int'($urandom_range(0, 4095)) - 2048;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 4);
        errors++;
        $display("FAIL watchdog expired got %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd7741));
        for (int e = 0; e < N; e++) begin
            for (int i = 0; i < 8; i++) mreg[e][i] = 0;
            mflag[e] = 1'b1;
            mpix[e] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: all registers zero, then all elements accept the first write
        for (int s = 0; s < 8; s++) chk_rd('1, '1, 3'(s), "R1 reset zero");
        exec(3'd1, 10'(1 << 9), 3'd0, 2'd0, 5, 3'd0);
        chk_rd('1, '1, 3'd0, "R1 flags set after reset");

        // R4: sign-extended immediate
        exec(3'd1, 10'(1 << 9), 3'd1, 2'd0, -64, 3'd0);
        chk_elem(5, 3'd1, "R4 imm -64");
        exec(3'd1, 10'(1 << 9), 3'd2, 2'd0, 63, 3'd0);
        chk_elem(10, 3'd2, "R4 imm 63");

        // R5: per-element pixel sampling
        rand_pix();
        exec(3'd1, 10'(1 << 8), 3'd3, 2'd0, 0, 3'd0);
        chk_every(3'd3, "R5 pixel");

        // R2: several sources summed and negated in one instruction
        exec(3'd1, 10'b10_0000_1110, 3'd4, 2'd0, 7, 3'd0);
        chk_every(3'd4, "R2 multi-source");

        // R6: scaling path for every scale code
        exec(3'd1, 10'(1 << 3), 3'd7, 2'd0, 0, 3'd0);
        for (int k = 0; k < 8; k++) begin
            exec(3'd1, 10'(1 << 7), 3'd0, 2'd0, 0, 3'(k));
            chk_every(3'd0, "R6 scale");
        end

        // R3: saturation of negation and of sums
        for (int e = 0; e < N; e++) mpix[e] = LO;
        exec(3'd1, 10'(1 << 8), 3'd0, 2'd0, 0, 3'd0);
        chk_elem(0, 3'd0, "R3 negate most negative");
        for (int e = 0; e < N; e++) mpix[e] = HI;
        exec(3'd1, 10'b01_0000_0001, 3'd1, 2'd0, 0, 3'd0);
        chk_elem(3, 3'd1, "R3 negative saturation");
        exec(3'd1, 10'(1 << 1), 3'd2, 2'd0, 0, 3'd0);
        chk_elem(7, 3'd2, "R3 min to max");

        // R7: neighbour exchange in all four directions
        rand_pix();
        exec(3'd1, 10'(1 << 8), 3'd0, 2'd0, 0, 3'd0);
        for (int d = 0; d < 4; d++) begin
            exec(3'd2, 10'(1 << 0), 3'd0, 2'(d), 0, 3'd0);
            chk_every(3'd6, "R7 exchange");
        end
        exec(3'd2, 10'(1 << 9), 3'd0, 2'd0, 40, 3'd0);
        chk_elem(0, 3'd6, "R7 edge zero");
        chk_elem(5, 3'd6, "R7 inner");
        // smoothing step: sum of exchange results
        exec(3'd1, 10'b00_0100_0001, 3'd1, 2'd0, 0, 3'd0);
        chk_every(3'd1, "R7 smoothing");

        // R8 and R10: threshold then probe which elements accept writes
        exec(3'd3, 10'b10_0000_0001, 3'd0, 2'd0, -20, 3'd0);
        exec(3'd1, 10'(1 << 9), 3'd5, 2'd0, -1, 3'd0);
        chk_every(3'd5, "R8 threshold flag");
        exec(3'd3, 10'(1 << 9), 3'd0, 2'd0, -1, 3'd0);
        exec(3'd1, 10'(1 << 9), 3'd5, 2'd0, 9, 3'd0);
        exec(3'd2, 10'(1 << 9), 3'd0, 2'd1, 9, 3'd0);
        for (int s = 0; s < 8; s++) chk_rd('1, '1, 3'(s), "R10 inactive ignore");
        exec(3'd3, 10'(1 << 9), 3'd0, 2'd0, 0, 3'd0);
        exec(3'd1, 10'(1 << 9), 3'd5, 2'd0, -3, 3'd0);
        chk_rd('1, '1, 3'd5, "R8 compare ungated by old flag");

        // R9: global flag set
        exec(3'd3, 10'(1 << 9), 3'd0, 2'd0, -5, 3'd0);
        exec(3'd4, 10'd0, 3'd0, 2'd0, 0, 3'd0);
        exec(3'd1, 10'(1 << 9), 3'd5, 2'd0, -1, 3'd0);
        chk_rd('1, '1, 3'd5, "R9 set all flags");

        // R11: row, column, global, empty and mixed readouts
        for (int r = 0; r < ROWS; r++) chk_rd(ROWS'(1 << r), '1, 3'd3, "R11 row sum");
        for (int c = 0; c < COLS; c++) chk_rd('1, COLS'(1 << c), 3'd3, "R11 column sum");
        chk_rd('1, '1, 3'd3, "R11 global sum");
        chk_rd('0, '1, 3'd3, "R11 none selected");
        chk_rd(4'b0101, 4'b0110, 3'd1, "R11 mixed");

        // R12: no-op and unused opcodes with busy fields
        for (int i = 0; i < 8; i++) begin
            exec(3'(i % 4 == 0 ? 0 : 4 + (i % 4)), 10'($urandom_range(1, 1023)),
                 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), -10, 3'd7);
        end
        for (int s = 0; s < 8; s++) chk_rd('1, '1, 3'(s), "R12 no effect");
        exec(3'd1, 10'(1 << 9), 3'd5, 2'd0, -2, 3'd0);
        chk_every(3'd5, "R12 flags kept");

        // R2: seeded random programs
        for (int it = 0; it < 300; it++) begin
            int pick = int'($urandom_range(0, 9));
            logic [2:0] o;
            if (it % 25 == 0) rand_pix();
            o = (pick < 6) ? 3'd1 : (pick < 8) ? 3'd2 : (pick == 8) ? 3'd3 : 3'd4;
            exec(o, 10'($urandom_range(0, 1023)), 3'($urandom_range(0, 7)),
                 2'($urandom_range(0, 3)), int'($urandom_range(0, 127)) - 64,
                 3'($urandom_range(0, 7)));
            chk_rd(ROWS'($urandom_range(0, 15)), COLS'($urandom_range(0, 15)),
                   3'($urandom_range(0, 7)), "R2 random program");
            chk_elem(int'($urandom_range(0, N - 1)), 3'($urandom_range(0, 7)),
                     "R2 random element");
        end

        finish_run();
    end
endmodule